// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Arbiter

This block sits between the interrupt sources of a processor core and its exception entry logic. It keeps one pending bit per interrupt source. Each cycle it looks at the pending bits, works out which sources may be taken under the current machine state (external enable, critical enable, hypervisor state) and a few control inputs, and presents the single highest-priority deliverable source as an exception code with a valid strobe. The code and strobe are combinational from the pending register and the state inputs, so a delivery is visible in the same cycle in which the conditions allow it.

On the clock edge that ends a delivery cycle, the pending bit of the delivered source is cleared, unless that source is level-driven and has to be cleared by its producer. The decrementer source is cleared or kept depending on a configuration input. A power-save entry strobe throws away a pending hypervisor decrementer request. Sources raise their pending bits through a per-source set vector, and a set always wins over a clear on the same bit in the same cycle.

Top module: `int_deliver_arb`

## Requirements
- R1: Source numbering, which is also the pending bit position and the delivered code: 0 system reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. After a synchronous reset (rst_n low at a clock edge) all pending bits are 0 and deliver_valid is 0.
- R2: Among the eligible pending sources, the one with the lowest number is delivered, and only that one. Sources 0 and 1 are always eligible.
- R3: Source 2 is eligible only when hdec_enable is 1 and either msr_ee is 1 or msr_hv is 0.
- R4: Source 3 is eligible when msr_ee is 1, or when hv_present is 1, msr_hv is 0 and ext_to_guest is 0. Delivering it leaves its pending bit set.
- R5: Source 4 is eligible only when msr_ce is 1. Delivering it leaves its pending bit set.
- R6: Sources 5 to 12 are eligible only when msr_ee is 1.
- R7: Delivering source 0, 1, 2, 5, 6, 7, 8, 10, 11 or 12 clears its pending bit at the next clock edge; other pending bits are unaffected.
- R8: Delivering source 9 clears its pending bit at the next edge only when decr_autoclear is 1; with decr_autoclear 0 it stays set.
- R9: A cycle with pwr_save_enter at 1 clears pending bit 2 at the next edge, whether or not anything is delivered.
- R10: When set_req and a clear (delivery or power-save) hit the same bit in the same cycle, the bit is 1 after the edge.
- R11: When no pending source is eligible, deliver_valid is 0, deliver_code is 0, and the pending bits keep their values (apart from bits raised by set_req).
- R12: A 1 on set_req[i] in a cycle makes pending bit i read 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_req | input | 13 | Per-source request to raise the pending bit |
| msr_ee | input | 1 | External interrupt enable from the machine state |
| msr_ce | input | 1 | Critical interrupt enable from the machine state |
| msr_hv | input | 1 | Hypervisor state bit from the machine state |
| hdec_enable | input | 1 | Allows hypervisor decrementer delivery |
| ext_to_guest | input | 1 | When 1, external interrupts never bypass the external enable |
| hv_present | input | 1 | Core implements a hypervisor mode |
| decr_autoclear | input | 1 | Decrementer pending bit is cleared on delivery |
| pwr_save_enter | input | 1 | Strobe marking entry into a power-save state |
| deliver_valid | output | 1 | A source is being delivered this cycle |
| deliver_code | output | 4 | Number of the delivered source, 0 when idle |
| pending | output | 13 | Current pending bits |

## Verification
The bench loads many pending patterns with progressively more low-priority-only content and, for each, walks all 128 combinations of the state and control inputs, comparing the delivered code and the next pending value with a model computed in the bench. This catches a priority chain that lets a later source jump an earlier one, a gate that lets the external source bypass its enable in the wrong hypervisor state, and a hypervisor decrementer that ignores its enable. Directed cases target the sticky sources: a design that cleared the external or critical bit on delivery would stop presenting the level-held request on the following cycle, and one that ignored decr_autoclear would lose or keep the decrementer bit wrongly. Same-cycle set-and-clear and power-save discard are checked at the pending output, where a clear that beat the set would show a dropped request.

// File: rtl/int_arb_pkg.sv
// Shared constants for the interrupt delivery arbiter.
// Assumes source numbers double as pending bit positions and delivered codes.
package int_arb_pkg;

    localparam int NUM_SRC = 13;
    localparam int CODE_W  = $clog2(NUM_SRC);

    // Source numbers in priority order, lowest number wins.
    localparam int SRC_SYSRST  = 0;
    localparam int SRC_MCHK    = 1;
    localparam int SRC_HYPDEC  = 2;
    localparam int SRC_EXTIN   = 3;
    localparam int SRC_CRITIN  = 4;
    localparam int SRC_WDOG    = 5;
    localparam int SRC_CDBELL  = 6;
    localparam int SRC_FIXTMR  = 7;
    localparam int SRC_PRGTMR  = 8;
    localparam int SRC_DECR    = 9;
    localparam int SRC_DBELL   = 10;
    localparam int SRC_PERF    = 11;
    localparam int SRC_THERMAL = 12;

    // First and last source of the group gated by the external enable alone.
    localparam int EE_GROUP_LO = SRC_WDOG;
    localparam int EE_GROUP_HI = SRC_THERMAL;

    // Sources that the producer clears (level-driven); never cleared here.
    localparam logic [NUM_SRC-1:0] LEVEL_MASK =
        NUM_SRC'((1 << SRC_EXTIN) | (1 << SRC_CRITIN));

    // Machine state and control view used by the gating logic.
    typedef struct packed {
        logic ee;
        logic ce;
        logic hv;
        logic hdec_en;
        logic ext_guest;
        logic hv_present;
    } gate_ctx_t;

endpackage

// File: rtl/int_arb_gate.sv
// Eligibility gating: turns the machine state and control inputs into one
// eligibility bit per source. Purely combinational.
// Assumes the source numbering of int_arb_pkg.
module int_arb_gate
    import int_arb_pkg::*;
(
    input  gate_ctx_t            ctx,
    output logic [NUM_SRC-1:0]   eligible
);

    // Ungated, hypervisor and external-path sources.
    always_comb begin
        eligible[SRC_SYSRST] = 1'b1;
        eligible[SRC_MCHK]   = 1'b1;
        eligible[SRC_HYPDEC] = ctx.hdec_en & (ctx.ee | ~ctx.hv);
        eligible[SRC_EXTIN]  = ctx.ee |
                               (ctx.hv_present & ~ctx.hv & ~ctx.ext_guest);
        eligible[SRC_CRITIN] = ctx.ce;
    end

    // The trailing group depends on the external enable only.
    for (genvar g = EE_GROUP_LO; g <= EE_GROUP_HI; g++) begin : g_ee_group
        assign eligible[g] = ctx.ee;
    end

endmodule

// File: rtl/int_arb_pick.sv
// Fixed-priority picker: grants the lowest-numbered requesting input and
// encodes its index. Index is zero when nothing requests.
// Assumes N >= 2 and W wide enough to hold N-1.
module int_arb_pick #(
    parameter int N = 13,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any,
    output logic [W-1:0] index
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Ripple a "higher priority already requested" flag down the chain.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]    = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

    assign any = seen[N];

    // Encode the single granted position into a binary index.
    always_comb begin
        index = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                index = index | W'(i);
            end
        end
    end

endmodule

// File: rtl/int_arb_pend.sv
// Pending bit store: one register per source with set-over-clear priority.
// Assumes clr_vec and set_vec are valid every cycle; synchronous active-low reset.
module int_arb_pend #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Update one pending bit; a set beats a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                pend_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                pend_q[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> pend_q[i]); // R10
    end

endmodule

// File: rtl/int_deliver_arb.sv
// Interrupt delivery arbiter top. Holds per-source pending bits, gates them
// with the machine state, delivers the highest-priority eligible source each
// cycle (combinationally) and clears the delivered bit at the next edge for
// sources that are cleared on delivery.
// Assumes the inputs are synchronous to clk; synchronous active-low reset.
module int_deliver_arb
    import int_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [12:0]        set_req,
    input  logic               msr_ee,
    input  logic               msr_ce,
    input  logic               msr_hv,
    input  logic               hdec_enable,
    input  logic               ext_to_guest,
    input  logic               hv_present,
    input  logic               decr_autoclear,
    input  logic               pwr_save_enter,
    output logic               deliver_valid,
    output logic [3:0]         deliver_code,
    output logic [12:0]        pending
);

    gate_ctx_t            ctx;
    logic [NUM_SRC-1:0]   eligible;
    logic [NUM_SRC-1:0]   candidates;
    logic [NUM_SRC-1:0]   grant;
    logic [NUM_SRC-1:0]   clearable;
    logic [NUM_SRC-1:0]   clr_vec;
    logic [NUM_SRC-1:0]   pend_q;
    logic                 any;
    logic [CODE_W-1:0]    index;

    // Bundle the state and control inputs for the gating logic.
    always_comb begin
        ctx.ee         = msr_ee;
        ctx.ce         = msr_ce;
        ctx.hv         = msr_hv;
        ctx.hdec_en    = hdec_enable;
        ctx.ext_guest  = ext_to_guest;
        ctx.hv_present = hv_present;
    end

    int_arb_gate u_gate (
        .ctx      (ctx),
        .eligible (eligible)
    );

    assign candidates = pend_q & eligible;

    int_arb_pick #(
        .N (NUM_SRC),
        .W (CODE_W)
    ) u_pick (
        .req   (candidates),
        .grant (grant),
        .any   (any),
        .index (index)
    );

    // Per-source clear-on-delivery policy; the decrementer follows its input.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_policy
        if (i == SRC_DECR) begin : g_cfg
            assign clearable[i] = decr_autoclear;
        end else begin : g_fixed
            assign clearable[i] = ~LEVEL_MASK[i];
        end
    end

    // Clears come from the delivery and from power-save entry.
    always_comb begin
        clr_vec = grant & clearable;
        if (pwr_save_enter) begin
            clr_vec[SRC_HYPDEC] = 1'b1;
        end
    end

    int_arb_pend #(
        .N (NUM_SRC)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_req),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    assign deliver_valid = any;
    assign deliver_code  = index;
    assign pending       = pend_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2

    AST_DELIVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> pending[deliver_code]); // R2

    AST_HYPDEC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_code == CODE_W'(SRC_HYPDEC))
        |-> (hdec_enable && (msr_ee || !msr_hv))); // R3

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_code == CODE_W'(SRC_EXTIN))
        |=> pending[SRC_EXTIN]); // R4

    AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_code == CODE_W'(SRC_CRITIN))
        |=> (pending[SRC_CRITIN] && $past(msr_ce))); // R5

    AST_EE_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_code >= CODE_W'(EE_GROUP_LO)) |-> msr_ee); // R6

    AST_SYSRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid && deliver_code == CODE_W'(SRC_SYSRST) && !set_req[SRC_SYSRST])
        |=> !pending[SRC_SYSRST]); // R7

    AST_PWRSAVE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_save_enter && !set_req[SRC_HYPDEC]) |=> !pending[SRC_HYPDEC]); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!deliver_valid && set_req == '0 && !pwr_save_enter) |=> $stable(pending)); // R11

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver_valid |-> deliver_code == '0); // R11

endmodule

// File: tb/int_deliver_arb_bench.sv
module int_deliver_arb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] set_req = '0;
    logic        msr_ee = 1'b0, msr_ce = 1'b0, msr_hv = 1'b0;
    logic        hdec_enable = 1'b0, ext_to_guest = 1'b0, hv_present = 1'b0;
    logic        decr_autoclear = 1'b0, pwr_save_enter = 1'b0;
    logic        deliver_valid;
    logic [3:0]  deliver_code;
    logic [12:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] rs = 32'h1ace5eed;

    always #10 clk = ~clk;

    int_deliver_arb u_int_deliver_arb (
        .clk, .rst_n, .set_req, .msr_ee, .msr_ce, .msr_hv, .hdec_enable,
        .ext_to_guest, .hv_present, .decr_autoclear, .pwr_save_enter,
        .deliver_valid, .deliver_code, .pending
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // g bits: 0 ee, 1 ce, 2 hv, 3 hdec_enable, 4 ext_to_guest, 5 hv_present, 6 decr_autoclear
    task automatic drive_gates(input logic [6:0] g);
        msr_ee = g[0]; msr_ce = g[1]; msr_hv = g[2]; hdec_enable = g[3];
        ext_to_guest = g[4]; hv_present = g[5]; decr_autoclear = g[6];
    endtask

    // Expected {valid, code} from the requirement text.
    function automatic logic [4:0] model_pick(input logic [12:0] p, input logic [6:0] g);
        logic [12:0] el;
        el = '0;
        el[0] = 1'b1;
        el[1] = 1'b1;
        el[2] = g[3] & (g[0] | ~g[2]);
        el[3] = g[0] | (g[5] & ~g[2] & ~g[4]);
        el[4] = g[1];
        for (int k = 5; k < 13; k++) el[k] = g[0];
        for (int k = 12; k >= 0; k--) begin
            if (p[k] & el[k]) model_pick = {1'b1, 4'(k)};
        end
        if ((p & el) == '0) model_pick = 5'd0;
    endfunction

    function automatic logic [12:0] model_next(input logic [12:0] p, input logic [6:0] g);
        logic [4:0] r;
        r = model_pick(p, g);
        model_next = p;
        if (r[4] && r[3:0] != 4'd3 && r[3:0] != 4'd4 && !(r[3:0] == 4'd9 && !g[6]))
            model_next[r[3:0]] = 1'b0;
    endfunction

    function automatic string pick_tag(input logic [4:0] r);
        if (!r[4]) return "R11";
        case (r[3:0])
            4'd0, 4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Reset, then raise pattern p; returns at the negedge where pending == p.
    task automatic load(input logic [12:0] p);
        @(negedge clk); rst_n = 1'b0; set_req = '0;
        @(negedge clk); rst_n = 1'b1; set_req = p;
        @(negedge clk); set_req = '0;
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "reset pending", int'(pending), 0);
        chk("R1", "reset valid", int'(deliver_valid), 0);

        // R12 and R11: raise thermal with EE off; nothing deliverable, bit held
        drive_gates(7'b0000000);
        load(13'h1000);
        #2;
        chk("R12", "set raises pending", int'(pending), 'h1000);
        chk("R11", "idle valid", int'(deliver_valid), 0);
        chk("R11", "idle code", int'(deliver_code), 0);
        @(negedge clk);
        chk("R11", "idle hold", int'(pending), 'h1000);

        // R10: deliver thermal while its set is active; then R7 clear
        drive_gates(7'b0000001);
        set_req = 13'h1000;
        #2;
        chk("R6", "thermal delivered", int'(deliver_code), 12);
        @(negedge clk);
        chk("R10", "set beats delivery clear", int'(pending), 'h1000);
        set_req = '0;
        @(negedge clk);
        chk("R7", "thermal cleared", int'(pending), 0);

        // R9: power-save discards hypervisor decrementer; with set it survives (R10)
        drive_gates(7'b0000000);
        load(13'h0004 | 13'h0200);
        pwr_save_enter = 1'b1;
        @(negedge clk);
        chk("R9", "power save drops hdec", int'(pending), 'h0200);
        set_req = 13'h0004;
        @(negedge clk);
        chk("R10", "set beats power save", int'(pending), 'h0204);
        pwr_save_enter = 1'b0;
        set_req = '0;

        // R4: level external request stays and is re-delivered each cycle
        drive_gates(7'b0000001);
        load(13'h0008);
        for (int c = 0; c < 3; c++) begin
            #2;
            chk("R4", "ext valid", int'(deliver_valid), 1);
            chk("R4", "ext code", int'(deliver_code), 3);
            @(negedge clk);
            chk("R4", "ext stays pending", int'(pending), 'h0008);
        end

        // R5: critical held after delivery
        drive_gates(7'b0000010);
        load(13'h0010);
        #2;
        chk("R5", "crit code", int'(deliver_code), 4);
        @(negedge clk);
        chk("R5", "crit stays pending", int'(pending), 'h0010);

        // R8: decrementer clear depends on decr_autoclear
        drive_gates(7'b0000001);
        load(13'h0200);
        @(negedge clk);
        chk("R8", "decr kept without autoclear", int'(pending), 'h0200);
        drive_gates(7'b1000001);
        @(negedge clk);
        chk("R8", "decr cleared with autoclear", int'(pending), 0);

        // Sweep: R2..R8 and R11 against the model
        for (int i = 0; i < 150; i++) begin
            logic [12:0] p;
            rs = next_rand(rs);
            p = rs[12:0] & ~13'((1 << (i % 13)) - 1);
            for (int g = 0; g < 128; g++) begin
                logic [4:0]  r;
                logic [12:0] nx;
                drive_gates(7'(g));
                r = model_pick(p, 7'(g));
                nx = model_next(p, 7'(g));
                load(p);
                #2;
                chk(pick_tag(r), "sweep valid", int'(deliver_valid), int'(r[4]));
                chk(pick_tag(r), "sweep code", int'(deliver_code), int'(r[3:0]));
                @(negedge clk);
                chk((r[4] && r[3:0] == 4'd9) ? "R8" : "R7", "sweep next pending",
                    int'(pending), int'(nx));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule